// File: doc/BRIEF.md
# Shadowed Up/Down PWM Timer

This block is a general-purpose counter that produces one pulse-width-modulated output. A host programs it through a small register port: a control word, a period buffer, a compare buffer, the live count, a sticky event-flag register and an interrupt mask. The counter can hold, count up and wrap (edge-aligned PWM), count up and down (centre-aligned PWM) or follow an external direction input. Its count clock is the system clock divided by a power of two.

The period and compare values are double-buffered. Software writes the buffers at any time. The active period is replaced only when the count next reaches zero. The active compare value is replaced at a point the control word selects. Four events are recorded as flags: zero, period match, compare match and all-ones overflow. Each flag can raise an interrupt line, and one event can be chosen to emit a one-cycle ADC-start pulse.

Top module: `gp_pwm_timer`

## Requirements
- R1: After reset every register reads zero except control bit 15 (direction status), which reads 1. `pwm_out`, `irq` and `adc_start` are low. Register addresses are: 0 control, 1 period buffer, 2 compare buffer, 3 count, 4 flags, 5 mask.
- R2: Control bits [1:0] select the count mode: 0 hold, 1 up/down, 2 up, 3 directional. In hold mode the count never changes except by a host write to address 3, the written value reads back, and the active period and compare values follow their buffers.
- R3: In up mode the count steps 0,1,…,P and then returns to 0, so one cycle lasts P+1 count ticks, where P is the active period.
- R4: In up/down mode the count rises from 0 to P and falls back to 0 with no pause, so one cycle lasts 2·P ticks.
- R5: In directional mode with `dir_in`=1 the count rises and wraps from P to 0. With `dir_in`=0 it falls and wraps from 0 to P.
- R6: Control bits [4:2] hold a prescale code N, and the counter advances once every 2^N clocks.
- R7: A write to the period buffer takes effect only when the count next reaches zero. Until then the old period still bounds the count.
- R8: Control bits [6:5] set the compare reload point: 0 at zero, 1 at zero or period match, 2 immediately on a write to the compare buffer, 3 behaves like 0.
- R9: Control bits [8:7] condition the output: 0 forced low, 1 active low, 2 active high, 3 forced high. With compare enable (bit 9) clear, the output sits at its inactive level.
- R10: With compare enabled, up mode makes the output active from compare match until period match, active for P−C counts per cycle, where C is the compare value. Up/down mode toggles it at each compare match, active for 2·(P−C) counts per cycle.
- R11: Flag bits are 0 zero, 1 period match, 2 compare match, 3 count reached all ones. A flag sets on its event and stays set until the host writes 1 to it. Writing 0 leaves it unchanged. `irq` is the flags ANDed with the mask.
- R12: Control bits [11:10] choose the event that pulses `adc_start` for one cycle: 0 none, 1 zero, 2 period match, 3 compare match.
- R13: `cnt_up` and control bit 15 show the count direction, 1 meaning up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dir_in | input | 1 | Count direction in directional mode |
| pwm_out | output | 1 | Conditioned PWM output |
| cnt_up | output | 1 | Count direction status |
| irq | output | 4 | Masked event flags |
| adc_start | output | 1 | One-cycle conversion start pulse |

## Verification
Edge-aligned runs sweep every compare value below each period from 2 to 5. Active-high and active-low conditioning alternate, so a wrong duty count separates a wrong match rule from a wrong polarity. Centre-aligned runs sweep the same space, and their count traces show whether the turnaround at the peak and at zero costs or adds a tick. A prescale sweep stretches one fixed waveform by 1, 2, 4 and 8 to expose an off-by-one in the divider. Mid-cycle buffer writes, sampled at chosen counts on the rising and falling slopes, tell the three compare reload points apart and show that the period waits for zero.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int PSC_W  = 3;
    localparam int EVT_N  = 4;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        CM_HOLD = 2'd0,
        CM_UPDN = 2'd1,
        CM_UP   = 2'd2,
        CM_DIRN = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        RL_ZERO     = 2'd0,
        RL_ZERO_PRD = 2'd1,
        RL_IMM      = 2'd2,
        RL_RSVD     = 2'd3
    } reload_e;

    typedef enum logic [1:0] {
        OC_LOW    = 2'd0,
        OC_ACT_LO = 2'd1,
        OC_ACT_HI = 2'd2,
        OC_HIGH   = 2'd3
    } ocond_e;

    typedef enum logic [1:0] {
        AS_NONE = 2'd0,
        AS_ZERO = 2'd1,
        AS_PRD  = 2'd2,
        AS_CMP  = 2'd3
    } adcsel_e;

    typedef struct packed {
        adcsel_e           adc;
        logic              cmp_en;
        ocond_e            oc;
        reload_e           rl;
        logic [PSC_W-1:0]  psc;
        cmode_e            mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic ovf;
        logic cmp;
        logic prd;
        logic zero;
    } evt_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLG  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MSK  = 3'd5;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (2 ** PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t              q, d;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            lim[i] = (i < int'(sel));
        end
        at_lim = (q.cnt >= lim);
        tick   = run && at_lim;
        d      = q;
        if (!run || at_lim) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cmode_e       mode,
    input  logic         dir_in,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] cmp,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         up,
    output evt_t         evt
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } st_t;

    st_t          q, d;
    logic [W-1:0] nx;

    always_comb begin
        d  = q;
        nx = q.cnt;
        if (mode == CM_UP) d.up = 1'b1;
        if (tick) begin
            unique case (mode)
                CM_UP: begin
                    nx = (q.cnt >= prd) ? '0 : q.cnt + ONE;
                end
                CM_UPDN: begin
                    if (q.up) begin
                        if (q.cnt >= prd) begin
                            if (prd == '0) begin
                                nx = '0;
                            end else begin
                                nx   = q.cnt - ONE;
                                d.up = 1'b0;
                            end
                        end else begin
                            nx = q.cnt + ONE;
                        end
                    end else if (q.cnt == '0) begin
                        d.up = 1'b1;
                        nx   = (prd == '0) ? '0 : ONE;
                    end else begin
                        nx = q.cnt - ONE;
                    end
                end
                CM_DIRN: begin
                    d.up = dir_in;
                    if (dir_in) nx = (q.cnt >= prd) ? '0 : q.cnt + ONE;
                    else        nx = (q.cnt == '0) ? prd : q.cnt - ONE;
                end
                default: nx = q.cnt;
            endcase
            d.cnt = nx;
        end
        if (ld) d.cnt = ld_val;

        evt.zero = tick && !ld && (nx == '0);
        evt.prd  = tick && !ld && (nx == prd);
        evt.cmp  = tick && !ld && (nx == cmp);
        evt.ovf  = tick && !ld && (nx == ONES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.up  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;
    assign up  = q.up;
endmodule

// File: rtl/gpt_shadow.sv
module gpt_shadow
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  reload_e      rl,
    input  logic [W-1:0] prd_buf,
    input  logic [W-1:0] cmp_buf,
    input  logic         at_zero,
    input  logic         at_prd,
    input  logic         imm_we,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] prd_act,
    output logic [W-1:0] cmp_act
);
    typedef struct packed {
        logic [W-1:0] prd;
        logic [W-1:0] cmp;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (hold || at_zero) d.prd = prd_buf;

        if (rl == RL_IMM && imm_we) begin
            d.cmp = imm_val;
        end else if (hold) begin
            d.cmp = cmp_buf;
        end else begin
            unique case (rl)
                RL_ZERO_PRD: if (at_zero || at_prd) d.cmp = cmp_buf;
                RL_IMM:      d.cmp = cmp_buf;
                default:     if (at_zero) d.cmp = cmp_buf;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prd_act = q.prd;
    assign cmp_act = q.cmp;
endmodule

// File: rtl/gpt_outlogic.sv
module gpt_outlogic
    import gpt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cmode_e mode,
    input  ocond_e oc,
    input  logic   en,
    input  logic   at_prd,
    input  logic   at_cmp,
    output logic   pwm
);
    typedef struct packed {
        logic act;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.act = 1'b0;
        end else if (mode == CM_UP) begin
            if (at_prd)      d.act = 1'b0;
            else if (at_cmp) d.act = 1'b1;
        end else if (mode != CM_HOLD) begin
            if (at_cmp) d.act = ~q.act;
        end

        unique case (oc)
            OC_LOW:    pwm = 1'b0;
            OC_ACT_LO: pwm = ~q.act;
            OC_ACT_HI: pwm = q.act;
            default:   pwm = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gp_pwm_timer.sv
module gp_pwm_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              dir_in,
    output logic              pwm_out,
    output logic              cnt_up,
    output logic [EVT_N-1:0]  irq,
    output logic              adc_start
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] prd_buf;
        logic [CNT_W-1:0] cmp_buf;
        logic [EVT_N-1:0] flg;
        logic [EVT_N-1:0] msk;
        logic             adc;
    } regs_t;

    regs_t            q, d;
    logic             wr_ctrl, wr_prd, wr_cmp, wr_cnt, wr_flg, wr_msk;
    logic             tick;
    logic [CNT_W-1:0] cnt, prd_act, cmp_act;
    evt_t             evt;
    logic [EVT_N-1:0] evt_bits;
    logic [EVT_N-1:0] clr;
    cmode_e           mode;
    ocond_e           oc;
    adcsel_e          adc_sel;

    assign mode     = q.ctrl.mode;
    assign oc       = q.ctrl.oc;
    assign adc_sel  = q.ctrl.adc;
    assign evt_bits = evt;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == A_CTRL);
        wr_prd  = reg_we && (reg_addr == A_PRD);
        wr_cmp  = reg_we && (reg_addr == A_CMP);
        wr_cnt  = reg_we && (reg_addr == A_CNT);
        wr_flg  = reg_we && (reg_addr == A_FLG);
        wr_msk  = reg_we && (reg_addr == A_MSK);

        d = q;
        if (wr_ctrl) d.ctrl    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (wr_prd)  d.prd_buf = reg_wdata;
        if (wr_cmp)  d.cmp_buf = reg_wdata;
        if (wr_msk)  d.msk     = reg_wdata[EVT_N-1:0];

        clr   = wr_flg ? reg_wdata[EVT_N-1:0] : '0;
        d.flg = (q.flg & ~clr) | evt_bits;

        unique case (q.ctrl.adc)
            AS_ZERO: d.adc = evt.zero;
            AS_PRD:  d.adc = evt.prd;
            AS_CMP:  d.adc = evt.cmp;
            default: d.adc = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_W-1:0] = q.ctrl;
                reg_rdata[CNT_W-1]    = cnt_up;
            end
            A_PRD:   reg_rdata = q.prd_buf;
            A_CMP:   reg_rdata = q.cmp_buf;
            A_CNT:   reg_rdata = cnt;
            A_FLG:   reg_rdata[EVT_N-1:0] = q.flg;
            A_MSK:   reg_rdata[EVT_N-1:0] = q.msk;
            default: reg_rdata = '0;
        endcase
    end

    gpt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (mode != CM_HOLD),
        .sel  (q.ctrl.psc),
        .tick (tick)
    );

    gpt_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .mode  (mode),
        .dir_in(dir_in),
        .prd   (prd_act),
        .cmp   (cmp_act),
        .ld    (wr_cnt),
        .ld_val(reg_wdata),
        .cnt   (cnt),
        .up    (cnt_up),
        .evt   (evt)
    );

    gpt_shadow #(.W(CNT_W)) u_shd (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (mode == CM_HOLD),
        .rl     (q.ctrl.rl),
        .prd_buf(q.prd_buf),
        .cmp_buf(q.cmp_buf),
        .at_zero(evt.zero),
        .at_prd (evt.prd),
        .imm_we (wr_cmp),
        .imm_val(reg_wdata),
        .prd_act(prd_act),
        .cmp_act(cmp_act)
    );

    gpt_outlogic u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .oc    (oc),
        .en    (q.ctrl.cmp_en),
        .at_prd(evt.prd),
        .at_cmp(evt.cmp),
        .pwm   (pwm_out)
    );

    assign irq       = q.flg & q.msk;
    assign adc_start = q.adc;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
    import gpt_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input cmode_e            mode,
    input ocond_e            oc,
    input adcsel_e           adc_sel,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      prd_act,
    input logic              cnt_up,
    input logic              pwm_out,
    input logic [EVT_N-1:0]  flg,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              adc_start
);
    logic cnt_wr, flg_wr;
    assign cnt_wr = reg_we && (reg_addr == A_CNT);
    assign flg_wr = reg_we && (reg_addr == A_FLG);

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_HOLD && !cnt_wr) |=> $stable(cnt)); // R2

    AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP && cnt <= prd_act && !cnt_wr) |=> (cnt <= prd_act)); // R3

    AST_UP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP) |=> cnt_up); // R13

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oc == OC_LOW) |-> !pwm_out); // R9

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (oc == OC_HIGH) |-> pwm_out); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_wr |=> ((flg & $past(flg)) == $past(flg))); // R11

    AST_ADC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sel == AS_NONE) |=> !adc_start); // R12
endmodule

bind gp_pwm_timer gpt_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .oc       (oc),
    .adc_sel  (adc_sel),
    .cnt      (cnt),
    .prd_act  (prd_act),
    .cnt_up   (cnt_up),
    .pwm_out  (pwm_out),
    .flg      (q.flg),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .adc_start(adc_start)
);

// File: tb/sim_gp_pwm_timer.sv
`timescale 1ns/1ps
module sim_gp_pwm_timer;
    localparam logic [2:0] A_CTRL = 3'd0, A_PRD = 3'd1, A_CMP = 3'd2,
                           A_CNT = 3'd3, A_FLG = 3'd4, A_MSK = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = A_CNT;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dir_in = 1'b1;
    logic        pwm_out, cnt_up, adc_start;
    logic [3:0]  irq;

    int checks = 0;
    int fails = 0;
    int adc_seen = 0;

    always #2.5 clk = ~clk;

    gp_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_in(dir_in),
        .pwm_out(pwm_out), .cnt_up(cnt_up), .irq(irq), .adc_start(adc_start)
    );

    function automatic logic [15:0] mk(input int mode, input int psc, input int rl,
                                       input int oc, input int en, input int adc);
        return 16'((adc << 10) | (en << 9) | (oc << 7) | (rl << 5) | (psc << 2) | mode);
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_CNT;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
        reg_addr = A_CNT;
    endtask

    task automatic smp(output int c, output logic p);
        @(negedge clk);
        #1;
        c = int'(reg_rdata);
        p = pwm_out;
        if (adc_start) adc_seen++;
    endtask

    task automatic cfg(input int per, input int cm);
        wr(A_CTRL, mk(0, 0, 0, 2, 0, 0));
        wr(A_CNT, 16'd0);
        wr(A_PRD, 16'(per));
        wr(A_CMP, 16'(cm));
    endtask

    // skip settling samples, then collect a window: high count, extremes, period mismatches
    task automatic run_win(input int skip, input int w, input int plen,
                           output int hi, output int mx, output int mn, output int bad);
        int s [0:127];
        int c;
        logic p;
        for (int i = 0; i < skip; i++) smp(c, p);
        hi = 0; mx = 0; mn = 65535; bad = 0;
        for (int i = 0; i < w; i++) begin
            smp(c, p);
            s[i] = c;
            if (p) hi++;
            if (c > mx) mx = c;
            if (c < mn) mn = c;
        end
        for (int i = 0; i + plen < w; i++) if (s[i + plen] != s[i]) bad++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v, hi, mx, mn, bad, c, a, err, oc, win;
        int p7, p4;
        logic p;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h8000);
        rd(A_PRD, v);  chk("R1 period buffer", v, 0);
        rd(A_CMP, v);  chk("R1 compare buffer", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_FLG, v);  chk("R1 flags", v, 0);
        rd(A_MSK, v);  chk("R1 mask", v, 0);
        chk("R1 outputs", {29'd0, pwm_out, irq != 0, adc_start}, 0);

        // R2: hold mode freezes a written count
        wr(A_CNT, 16'd5);
        wr(A_PRD, 16'd9);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R2 hold count", v, 5);
        rd(A_FLG, v); chk("R2 hold no events", v, 0);

        // R3 R10 R9: up-mode sweep, polarity alternating
        adc_seen = 0;
        for (int per = 2; per <= 5; per++) begin
            for (int cm = 0; cm < per; cm++) begin
                oc = (cm % 2 == 0) ? 2 : 1;
                cfg(per, cm);
                wr(A_CTRL, mk(2, 0, 0, oc, 1, 0));
                win = 2 * (per + 1);
                run_win(win, win, per + 1, hi, mx, mn, bad);
                chk("R3 up max count", mx, per);
                chk("R3 up cycle length", bad, 0);
                chk("R10 R9 up active count", hi, (oc == 2) ? 2 * (per - cm) : win - 2 * (per - cm));
            end
        end

        // R4 R10: up/down sweep
        for (int per = 2; per <= 5; per++) begin
            for (int cm = 1; cm < per; cm++) begin
                cfg(per, cm);
                wr(A_CTRL, mk(1, 0, 0, 2, 1, 0));
                win = 4 * per;
                run_win(win, win, 2 * per, hi, mx, mn, bad);
                chk("R4 updn max count", mx, per);
                chk("R4 updn min count", mn, 0);
                chk("R4 updn cycle length", bad, 0);
                chk("R10 updn active count", hi, 4 * (per - cm));
            end
        end

        // R6: prescale sweep, per=3 cmp=1 up mode
        for (int ps = 0; ps <= 3; ps++) begin
            cfg(3, 1);
            wr(A_CTRL, mk(2, ps, 0, 2, 1, 0));
            win = 2 * (4 << ps);
            run_win(win, win, 4 << ps, hi, mx, mn, bad);
            chk("R6 prescaled cycle", bad, 0);
            chk("R6 prescaled active count", hi, 2 * (2 << ps));
        end
        chk("R12 no adc pulse when none selected", adc_seen, 0);

        // R5 R13: directional mode
        cfg(5, 0);
        dir_in = 1'b1;
        wr(A_CTRL, mk(3, 0, 0, 2, 0, 0));
        smp(a, p);
        err = 0;
        for (int i = 0; i < 10; i++) begin
            smp(c, p);
            if (c != ((a == 5) ? 0 : a + 1)) err++;
            a = c;
        end
        chk("R5 dir up steps", err, 0);
        chk("R13 cnt_up while up", int'(cnt_up), 1);
        rd(A_CTRL, v); chk("R13 status bit up", (v >> 15) & 1, 1);
        dir_in = 1'b0;
        smp(c, p);
        smp(a, p);
        err = 0;
        for (int i = 0; i < 10; i++) begin
            smp(c, p);
            if (c != ((a == 0) ? 5 : a - 1)) err++;
            a = c;
        end
        chk("R5 dir down steps", err, 0);
        chk("R13 cnt_up while down", int'(cnt_up), 0);
        rd(A_CTRL, v); chk("R13 status bit down", (v >> 15) & 1, 0);
        dir_in = 1'b1;

        // R7: period buffer written mid-cycle waits for zero
        cfg(3, 1);
        wr(A_CTRL, mk(2, 0, 0, 2, 0, 0));
        c = -1;
        for (int i = 0; i < 20 && c != 1; i++) smp(c, p);
        wr(A_PRD, 16'd6);
        err = 0;
        for (int i = 0; i < 8; i++) begin
            smp(c, p);
            if (c != ((i == 7) ? 0 : i)) err++;
        end
        chk("R7 period reload at zero", err, 0);

        // R8: compare reload point, up/down per=10 cmp=2, buffer set to 8 at count 4 rising
        for (int rl = 0; rl <= 3; rl++) begin
            cfg(10, 2);
            wr(A_CTRL, mk(1, 0, rl, 2, 1, 0));
            c = -1;
            for (int i = 0; i < 40 && !(c == 4 && cnt_up); i++) smp(c, p);
            wr(A_CMP, 16'd8);
            p7 = -1; p4 = -1;
            for (int i = 0; i < 40 && p4 < 0; i++) begin
                smp(c, p);
                if (c == 9 && cnt_up && p7 < 0) p7 = int'(p);
                if (c == 6 && !cnt_up && p7 >= 0) p4 = int'(p);
            end
            chk($sformatf("R8 reload %0d rising", rl), p7, (rl == 2) ? 0 : 1);
            chk($sformatf("R8 reload %0d falling", rl), p4, (rl == 1) ? 0 : 1);
        end

        // R9: conditioning with compare disabled
        for (int o = 0; o < 4; o++) begin
            wr(A_CTRL, mk(0, 0, 0, o, 0, 0));
            smp(c, p);
            chk($sformatf("R9 idle level oc=%0d", o), int'(p), (o == 0 || o == 2) ? 0 : 1);
        end

        // R11 R12: overflow, period, zero, compare flags and adc pulse
        wr(A_CTRL, mk(0, 0, 0, 2, 0, 0));
        wr(A_PRD, 16'hFFFF);
        wr(A_CMP, 16'd5);
        wr(A_CNT, 16'hFFFD);
        wr(A_FLG, 16'hF);
        adc_seen = 0;
        wr(A_CTRL, mk(2, 0, 0, 2, 0, 2));
        for (int i = 0; i < 12; i++) smp(c, p);
        wr(A_CTRL, mk(0, 0, 0, 2, 0, 0));
        chk("R12 one period pulse", adc_seen, 1);
        rd(A_FLG, v); chk("R11 all flags set", v, 15);
        chk("R11 irq masked off", int'(irq), 0);
        wr(A_MSK, 16'h5);
        smp(c, p);
        chk("R11 irq under mask", int'(irq), 5);
        wr(A_FLG, 16'h0);
        rd(A_FLG, v); chk("R11 write zero ignored", v, 15);
        wr(A_FLG, 16'h3);
        rd(A_FLG, v); chk("R11 write one clears", v, 12);
        chk("R11 irq after clear", int'(irq), 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule